// File: doc/BRIEF.md
# Selectable Interleaved or Linear Burst Offset Sequencer

This block generates the low-order word offset inside a four-beat burst. When an address strobe is accepted, the surrounding logic pulses a load input and presents the low address bits. The block captures them as the burst's starting offset. After that, every cycle in which the active-low advance input is asserted moves the burst to its next beat. When advance is deasserted, the burst pauses. It resumes from the same beat when advance is asserted again.

Two burst orders are available, chosen by a static strap. In linear order the offset counts upward from the start and wraps modulo the burst length. In interleaved order each offset is the start value XOR the beat number. Both orders are derived from one beat counter, and that counter is kept apart from the captured start value. The block outputs the current offset and the beat index. The enclosing address path uses the offset, and burst control logic can use the beat index. The offset width is a parameter, with a default of 2 bits (four beats).

Top module: `burst_order_gen`

## Requirements
- R1: While reset is asserted, the offset and the beat index are both zero.
- R2: A clock edge with `load_i` high captures `start_i`. From the next cycle the beat index is 0 and the offset equals the captured start.
- R3: When `order_i` is 1 (interleaved), the offset equals the captured start XOR the beat index. For example, start 01 gives 01, 00, 11, 10, and start 10 gives 10, 11, 00, 01.
- R4: When `order_i` is 0 (linear), the offset equals the captured start plus the beat index, modulo 4. For example, start 01 gives 01, 10, 11, 00.
- R5: A clock edge with `adv_n_i` low and `load_i` low increments the beat index by one.
- R6: A clock edge with `adv_n_i` high and `load_i` low leaves the beat index and the offset unchanged.
- R7: Advancing from beat 3 wraps the burst. The beat index returns to 0 and the offset returns to the captured start.
- R8: When `load_i` and an asserted `adv_n_i` occur at the same edge, the load wins and the beat index becomes 0, not 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Accepted-strobe pulse; captures the start offset |
| start_i | input | 2 | Low address bits that give the burst's start offset |
| adv_n_i | input | 1 | Advance to the next beat, active low |
| order_i | input | 1 | Static order strap: 0 selects linear, 1 selects interleaved |
| offset_o | output | 2 | Current burst offset |
| beat_o | output | 2 | Current beat index, 0 to 3 |

## Verification
The bound checker tracks its own copy of the captured start. Against it, every cycle it checks the XOR and modulo-add relations between offset and beat in both orders. It also checks that a step happens exactly when advance is asserted, that a paused burst holds, that a load takes priority, and that the burst wraps back to its start. The bench's scenarios are needed to show complete sequences end to end. These include a burst suspended mid-way and then resumed, back-to-back loads from each of the four start values, and a switch of the strap between bursts, all compared with a reference model built from the requirement formulas.

// File: rtl/burst_order_pkg.sv
package burst_order_pkg;
   typedef enum logic {
      ORD_LINEAR      = 1'b0,
      ORD_INTERLEAVED = 1'b1
   } order_e;

   localparam int unsigned MAX_OFS_W = 8;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
   parameter int unsigned OFS_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [OFS_W-1:0] start_i,
   output logic [OFS_W-1:0] start_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      start_q <= '0;
      else if (load_i) start_q <= start_i;
   end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int unsigned OFS_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             adv_n_i,
   output logic [OFS_W-1:0] beat_q
);
   localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

   // load clears the beat and wins over a step in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)        beat_q <= '0;
      else if (load_i)   beat_q <= '0;
      else if (!adv_n_i) beat_q <= beat_q + ONE;   // natural wrap to zero
   end
endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
   import burst_order_pkg::*;
#(
   parameter int unsigned OFS_W = 2
) (
   input  order_e           order_i,
   input  logic [OFS_W-1:0] start_i,
   input  logic [OFS_W-1:0] beat_i,
   output logic [OFS_W-1:0] offset_o
);
   logic [OFS_W-1:0] ilv_ofs;
   logic [OFS_W-1:0] lin_ofs;

   // interleaved order: bitwise toggle of the start by the beat number
   for (genvar b = 0; b < OFS_W; b++) begin : g_ilv_bit
      assign ilv_ofs[b] = start_i[b] ^ beat_i[b];
   end

   generate
      if (OFS_W == 1) begin : g_single
         // with one bit, modulo-2 add and XOR coincide
         assign lin_ofs = ilv_ofs;
      end else begin : g_wide
         assign lin_ofs = start_i + beat_i;
      end
   endgenerate

   always_comb begin
      offset_o = (order_i == ORD_INTERLEAVED) ? ilv_ofs : lin_ofs;
   end
endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
   import burst_order_pkg::*;
#(
   parameter int unsigned OFS_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [OFS_W-1:0] start_i,
   input  logic             adv_n_i,
   input  logic             order_i,
   output logic [OFS_W-1:0] offset_o,
   output logic [OFS_W-1:0] beat_o
);
   localparam int unsigned BEATS = 1 << OFS_W;

   initial begin
      if (OFS_W < 1 || OFS_W > MAX_OFS_W)
         $error("burst_order_gen: OFS_W=%0d out of range 1..%0d", OFS_W, MAX_OFS_W);
      if (BEATS < 2)
         $error("burst_order_gen: a burst needs at least two beats");
   end

   logic [OFS_W-1:0] start_q;
   logic [OFS_W-1:0] beat_q;
   order_e           order_sel;

   assign order_sel = order_e'(order_i);

   burst_start_reg #(.OFS_W(OFS_W)) u_start (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .start_i (start_i),
      .start_q (start_q)
   );

   burst_beat_ctr #(.OFS_W(OFS_W)) u_beat (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .adv_n_i (adv_n_i),
      .beat_q  (beat_q)
   );

   burst_offset_map #(.OFS_W(OFS_W)) u_map (
      .order_i  (order_sel),
      .start_i  (start_q),
      .beat_i   (beat_q),
      .offset_o (offset_o)
   );

   assign beat_o = beat_q;
endmodule

// File: rtl/burst_order_chk.sv
module burst_order_chk #(
   parameter int unsigned OFS_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_i,
   input logic [OFS_W-1:0] start_i,
   input logic             adv_n_i,
   input logic             order_i,
   input logic [OFS_W-1:0] offset_o,
   input logic [OFS_W-1:0] beat_o
);
   // checker-owned record of the last captured start
   logic [OFS_W-1:0] seen_start;
   always_ff @(posedge clk) begin
      if (!rst_n)      seen_start <= '0;
      else if (load_i) seen_start <= start_i;
   end

   // R1
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (offset_o == '0 && beat_o == '0));

   // R2
   a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (beat_o == '0 && offset_o == $past(start_i)));

   // R3
   a_r3_interleave: assert property (@(posedge clk) disable iff (!rst_n)
      order_i |-> (offset_o == (seen_start ^ beat_o)));

   // R4
   a_r4_linear: assert property (@(posedge clk) disable iff (!rst_n)
      !order_i |-> (offset_o == OFS_W'(seen_start + beat_o)));

   // R5
   a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_n_i) |=> (beat_o == OFS_W'($past(beat_o) + 1'b1)));

   // R6
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && adv_n_i) |=> $stable(beat_o));

   // R7
   a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_n_i && beat_o == '1) |=> (beat_o == '0 && offset_o == seen_start));

   // R8
   a_r8_load_first: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !adv_n_i) |=> (beat_o == '0));
endmodule

bind burst_order_gen burst_order_chk #(.OFS_W(OFS_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .load_i   (load_i),
   .start_i  (start_i),
   .adv_n_i  (adv_n_i),
   .order_i  (order_i),
   .offset_o (offset_o),
   .beat_o   (beat_o)
);

// File: tb/sim_burst_order_gen.sv
`timescale 1ns/1ps
module sim_burst_order_gen;
   localparam int W = 2;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load_i = 1'b0;
   logic [W-1:0] start_i = '0;
   logic         adv_n_i = 1'b1;
   logic         order_i = 1'b1;
   logic [W-1:0] offset_o;
   logic [W-1:0] beat_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   // reference state
   int m_start = 0;
   int m_idx   = 0;

   always #2 clk = ~clk;

   burst_order_gen #(.OFS_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i),
      .adv_n_i(adv_n_i), .order_i(order_i), .offset_o(offset_o), .beat_o(beat_o)
   );

   function automatic int exp_offset(int st, int idx, bit ilv);
      if (ilv) return st ^ idx;       // R3 formula
      return (st + idx) % N;          // R4 formula
   endfunction

   task automatic compare(string tag);
      int eo;
      eo = exp_offset(m_start, m_idx, order_i);
      n_vec++;
      if (int'(offset_o) != eo || int'(beat_o) != m_idx) begin
         n_bad++;
         $display("FAIL %s: offset=%0d beat=%0d expected offset=%0d beat=%0d",
                  tag, offset_o, beat_o, eo, m_idx);
      end
   endtask

   // drive at negedge, let one edge pass, update model, compare at next negedge
   task automatic step(bit ld, int st, bit adv_n, string tag);
      load_i  = ld;
      start_i = W'(st);
      adv_n_i = adv_n;
      @(posedge clk);
      if (ld) begin
         m_start = st;
         m_idx   = 0;
      end else if (!adv_n) begin
         m_idx = (m_idx + 1) % N;
      end
      @(negedge clk);
      compare(tag);
   endtask

   task automatic burst(int st, bit ilv, string tag);
      order_i = ilv;
      step(1, st, 1, tag);
      for (int k = 0; k < N; k++) step(0, 0, 0, tag);  // last step wraps (R7)
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: run did not end, got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1 reset");
      // R1: advance and load during reset have no effect
      adv_n_i = 1'b0; load_i = 1'b1; start_i = 2'd3;
      @(negedge clk);
      compare("R1 reset ignores inputs");
      load_i = 1'b0; adv_n_i = 1'b1;
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after release");

      // R2 + R3 interleaved, every start value
      for (int s = 0; s < N; s++) burst(s, 1'b1, "R3 interleaved");
      // R2 + R4 linear, every start value
      for (int s = 0; s < N; s++) burst(s, 1'b0, "R4 linear");

      // R6 suspend mid-burst then resume, R7 wrap
      order_i = 1'b1;
      step(1, 2, 1, "R2 load");
      step(0, 0, 0, "R5 step");
      step(0, 0, 1, "R6 hold");
      step(0, 0, 1, "R6 hold");
      step(0, 0, 0, "R5 resume");
      step(0, 0, 0, "R5 step");
      step(0, 0, 0, "R7 wrap");
      step(0, 0, 1, "R6 hold after wrap");

      // R8 load with advance asserted
      order_i = 1'b0;
      step(1, 1, 0, "R8 load beats advance");
      step(0, 0, 0, "R5 step");
      step(1, 3, 0, "R8 reload mid-burst");
      step(0, 0, 0, "R4 linear after reload");

      // mixed pseudo-random traffic
      begin
         logic [7:0] lf = 8'h5b;
         for (int i = 0; i < 300; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            if (i % 40 == 0) order_i = lf[0];
            step(lf[7] & lf[6], int'(lf[2:1]), lf[3], "R5 R6 mixed");
         end
      end

      // R1 reset mid-burst
      rst_n = 1'b0;
      @(posedge clk);
      m_start = 0; m_idx = 0;
      @(negedge clk);
      compare("R1 mid-burst reset");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule